// File: doc/BRIEF.md
# Multiprocessor Address Filter

This block sits behind the receive shifter of a 9-bit multidrop serial link. Each completed character reaches it as eight data bits plus a ninth flag. When the flag is high the character is an address byte. The filter compares each address byte against a compare value. It then uses an enable bit and a two-bit mode to decide two things about every received byte: whether it raises an interrupt request, and whether it is passed on to the consumer.

The filter keeps one state bit that records whether the most recent address byte matched. A matching address sets it and a mismatching address clears it. Reset also clears it. Changing the mode does not touch it. The bit is updated only while filtering is enabled, and it feeds the two modes that select on address. Each accepted byte produces a one-cycle request pulse, one clock after the valid strobe. The byte and its flag are placed on registered outputs in the same cycle. A byte that is not accepted changes nothing at the outputs.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset, irq_o is 0, byte_o is 0, addr_flag_o is 0, and the match state is clear.
- R2: With mp_en_i = 0, every byte strobed by rx_valid_i is accepted, whatever the address flag and the mode.
- R3: With mp_en_i = 1 and mp_mode_i = 2'b00, every byte is accepted, both address bytes (rx_addr_i = 1) and data bytes (rx_addr_i = 0).
- R4: With mp_en_i = 1 and mp_mode_i = 2'b01, only address bytes are accepted. Data bytes are dropped.
- R5: With mp_en_i = 1 and mp_mode_i = 2'b10, an address byte equal to cmp_addr_i is accepted, and so is every data byte after it. A mismatching address byte is dropped, and so is every data byte after it, until an address byte matches again.
- R6: With mp_en_i = 1 and mp_mode_i = 2'b11, address bytes are never accepted. A data byte is accepted only when the most recent address byte matched cmp_addr_i.
- R7: Data bytes that arrive after reset and before any address byte count as unmatched, so modes 2'b10 and 2'b11 drop them.
- R8: While mp_en_i = 1, the match state is updated by every address byte in every mode. It is not changed by a change of mode.
- R9: When a byte is dropped, irq_o stays 0 and byte_o and addr_flag_o keep their previous values.
- R10: For an accepted byte, irq_o is high for exactly the one clock cycle after the rx_valid_i cycle. In that same cycle byte_o and addr_flag_o carry the received byte and its flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe that marks a completed received byte |
| rx_byte_i | input | 8 | Received data bits |
| rx_addr_i | input | 1 | Ninth bit: 1 = address byte, 0 = data byte |
| cmp_addr_i | input | 8 | Address compare value |
| mp_en_i | input | 1 | Enables address filtering |
| mp_mode_i | input | 2 | Filter mode (see R3 to R6) |
| irq_o | output | 1 | Interrupt request pulse for an accepted byte |
| byte_o | output | 8 | Last accepted byte |
| addr_flag_o | output | 1 | Address flag of the last accepted byte |

## Verification
The assertions check the following on every cycle:
- a request pulse is never raised without a strobe in the cycle before;
- a disabled filter passes every byte;
- mode 01 never passes a data byte;
- mode 11 never passes an address byte;
- a matching address in mode 10 is always passed;
- the outputs hold when no byte arrives.

The sticky match behaviour can only be shown by the bench's scenarios. This covers data passing or not passing according to an address seen several bytes earlier, the unmatched state after reset, and a match that carries across a mode change. Those scenarios also show that dropped bytes leave the outputs untouched.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic [1:0] {
    MODE_ALL      = 2'b00,
    MODE_ADDR     = 2'b01,
    MODE_STICKY   = 2'b10,
    MODE_DATA_HIT = 2'b11
  } mp_mode_e;
endpackage

// File: rtl/mpf_match.sv
module mpf_match #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_addr_i,
  input  logic              mp_en_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic [DATA_W-1:0] cmp_addr_i,
  output logic              hit_o,
  output logic              match_q_o
);
  logic match_q;

  assign hit_o = (rx_byte_i == cmp_addr_i);

  // Only address bytes move the sticky state; mode is irrelevant here.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                match_q <= 1'b0;
    else if (rx_valid_i && rx_addr_i && mp_en_i) match_q <= hit_o;
  end

  assign match_q_o = match_q;
endmodule

// File: rtl/mpf_decide.sv
module mpf_decide
  import mpf_pkg::*;
(
  input  logic     mp_en_i,
  input  mp_mode_e mode_i,
  input  logic     rx_addr_i,
  input  logic     hit_i,
  input  logic     match_q_i,
  output logic     pass_o
);
  always_comb begin
    if (!mp_en_i) begin
      pass_o = 1'b1;
    end else begin
      unique case (mode_i)
        MODE_ALL:      pass_o = 1'b1;
        MODE_ADDR:     pass_o = rx_addr_i;
        MODE_STICKY:   pass_o = rx_addr_i ? hit_i : match_q_i;
        MODE_DATA_HIT: pass_o = !rx_addr_i && match_q_i;
        default:       pass_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mpf_out_reg.sv
module mpf_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              addr_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= take_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      addr_o <= 1'b0;
    end else if (take_i) begin
      byte_o <= byte_i;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
  import mpf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_addr_i,
  input  logic [DATA_W-1:0] cmp_addr_i,
  input  logic              mp_en_i,
  input  logic [1:0]        mp_mode_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              addr_flag_o
);
  logic hit, match_q, pass;

  mpf_match #(.DATA_W(DATA_W)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_addr_i  (rx_addr_i),
    .mp_en_i    (mp_en_i),
    .rx_byte_i  (rx_byte_i),
    .cmp_addr_i (cmp_addr_i),
    .hit_o      (hit),
    .match_q_o  (match_q)
  );

  mpf_decide u_decide (
    .mp_en_i   (mp_en_i),
    .mode_i    (mp_mode_e'(mp_mode_i)),
    .rx_addr_i (rx_addr_i),
    .hit_i     (hit),
    .match_q_i (match_q),
    .pass_o    (pass)
  );

  mpf_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (rx_valid_i && pass),
    .byte_i (rx_byte_i),
    .addr_i (rx_addr_i),
    .irq_o  (irq_o),
    .byte_o (byte_o),
    .addr_o (addr_flag_o)
  );
endmodule

// File: rtl/mp_addr_filter_chk.sv
module mp_addr_filter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_byte_i,
  input logic              rx_addr_i,
  input logic [DATA_W-1:0] cmp_addr_i,
  input logic              mp_en_i,
  input logic [1:0]        mp_mode_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] byte_o,
  input logic              addr_flag_o
);
  AST_IRQ_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !irq_o); // R10
  AST_BYPASS_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !mp_en_i |=> irq_o && byte_o == $past(rx_byte_i)); // R2
  AST_ADDR_MODE_DROPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && mp_en_i && mp_mode_i == 2'b01 && !rx_addr_i |=> !irq_o); // R4
  AST_DATA_MODE_DROPS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && mp_en_i && mp_mode_i == 2'b11 && rx_addr_i |=> !irq_o); // R6
  AST_STICKY_HIT_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && mp_en_i && mp_mode_i == 2'b10 && rx_addr_i && rx_byte_i == cmp_addr_i
    |=> irq_o && addr_flag_o); // R5
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(byte_o) && $stable(addr_flag_o)); // R9
endmodule

bind mp_addr_filter mp_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_byte_i   (rx_byte_i),
  .rx_addr_i   (rx_addr_i),
  .cmp_addr_i  (cmp_addr_i),
  .mp_en_i     (mp_en_i),
  .mp_mode_i   (mp_mode_i),
  .irq_o       (irq_o),
  .byte_o      (byte_o),
  .addr_flag_o (addr_flag_o)
);

// File: tb/mp_addr_filter_test.sv
module mp_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_addr = 1'b0;
  logic [7:0] cmp_addr = 8'h5A;
  logic       mp_en = 1'b0;
  logic [1:0] mp_mode = 2'b00;
  logic       irq;
  logic [7:0] byte_out;
  logic       addr_flag;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_b = 8'h00;
  logic       last_a = 1'b0;

  always #2 clk = ~clk;

  mp_addr_filter uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_valid_i  (rx_valid),
    .rx_byte_i   (rx_byte),
    .rx_addr_i   (rx_addr),
    .cmp_addr_i  (cmp_addr),
    .mp_en_i     (mp_en),
    .mp_mode_i   (mp_mode),
    .irq_o       (irq),
    .byte_o      (byte_out),
    .addr_flag_o (addr_flag)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Strobe one byte, then check the outputs at the next falling edge.
  task automatic send(input string req, input logic [7:0] b, input logic a, input logic exp_pass);
    @(negedge clk);
    rx_byte = b; rx_addr = a; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    if (exp_pass) begin last_b = b; last_a = a; end
    chk(req, {15'd0, irq}, {15'd0, exp_pass});
    chk(req, {7'd0, addr_flag, byte_out}, {7'd0, last_a, last_b});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    last_b = 8'h00; last_a = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", {7'd0, irq, addr_flag, byte_out}, 16'h0000);
    // match state clear: mode 11 data must be dropped
    mp_en = 1'b1; mp_mode = 2'b11;
    send("R1", 8'h11, 1'b0, 1'b0);
  endtask

  task automatic t_bypass();
    mp_en = 1'b0;
    for (int m = 0; m < 4; m++) begin
      mp_mode = m[1:0];
      send("R2", 8'h20 + 8'(m), 1'b0, 1'b1);
      send("R2", 8'h33, 1'b1, 1'b1);
    end
  endtask

  task automatic t_mode00();
    mp_en = 1'b1; mp_mode = 2'b00;
    send("R3", 8'h44, 1'b1, 1'b1);
    send("R3", 8'h45, 1'b0, 1'b1);
  endtask

  task automatic t_mode01();
    mp_en = 1'b1; mp_mode = 2'b01;
    send("R4", 8'h5A, 1'b1, 1'b1);
    send("R4", 8'h66, 1'b0, 1'b0);
    send("R4", 8'h01, 1'b1, 1'b1);
    send("R9", 8'h67, 1'b0, 1'b0);
  endtask

  task automatic t_mode10();
    do_reset();
    mp_en = 1'b1; mp_mode = 2'b10;
    send("R7", 8'h70, 1'b0, 1'b0);
    send("R5", 8'h5A, 1'b1, 1'b1);
    send("R5", 8'h71, 1'b0, 1'b1);
    send("R5", 8'h72, 1'b0, 1'b1);
    send("R5", 8'h13, 1'b1, 1'b0);
    send("R5", 8'h73, 1'b0, 1'b0);
    send("R9", 8'h74, 1'b0, 1'b0);
    send("R5", 8'h5A, 1'b1, 1'b1);
    send("R5", 8'h75, 1'b0, 1'b1);
  endtask

  task automatic t_mode11();
    do_reset();
    mp_en = 1'b1; mp_mode = 2'b11;
    send("R7", 8'h80, 1'b0, 1'b0);
    send("R6", 8'h5A, 1'b1, 1'b0);
    send("R6", 8'h81, 1'b0, 1'b1);
    send("R6", 8'h82, 1'b0, 1'b1);
    send("R6", 8'h99, 1'b1, 1'b0);
    send("R6", 8'h83, 1'b0, 1'b0);
  endtask

  task automatic t_mode_change();
    do_reset();
    mp_en = 1'b1; mp_mode = 2'b10;
    send("R8", 8'h5A, 1'b1, 1'b1);
    mp_mode = 2'b11;
    send("R8", 8'h90, 1'b0, 1'b1);
    // mismatching address in mode 00 clears the state
    mp_mode = 2'b00;
    send("R8", 8'h02, 1'b1, 1'b1);
    mp_mode = 2'b11;
    send("R8", 8'h91, 1'b0, 1'b0);
    // matching address in mode 01 sets it again
    mp_mode = 2'b01;
    send("R8", 8'h5A, 1'b1, 1'b1);
    mp_mode = 2'b10;
    send("R8", 8'h92, 1'b0, 1'b1);
  endtask

  task automatic t_pulse();
    mp_en = 1'b0;
    send("R10", 8'hA5, 1'b0, 1'b1);
    @(negedge clk);
    chk("R10", {15'd0, irq}, 16'h0000);
    chk("R10", {8'd0, byte_out}, 16'h00A5);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_mode00();
    t_mode01();
    t_mode10();
    t_mode11();
    t_mode_change();
    t_pulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule